// File: doc/BRIEF.md
# Self-Routing Omega Multistage Switch

This block moves up to eight packets per cycle from eight sources to eight sinks through three columns of 2x2 switching cells, four cells per column. A perfect-shuffle rewiring sits in front of every column. Each cell picks its output from a single bit of the packet's own destination tag, so no central controller builds the path. The first column uses the top tag bit and the last column uses the bottom bit. A clear bit sends the packet to the cell's upper output and a set bit sends it to the lower output.

Two packets can reach the same cell in one cycle and ask for the same output. In that case one of them goes on and the other is blocked at that column. A blocked packet uses no link after the column where it lost. Its source sees `in_ready` low and must present the same packet again in a later cycle. A parameter selects how each cell picks the winner: the upper input always wins, or each cell keeps a one-bit pointer that alternates priority between its two inputs.

The whole path is combinational within one cycle. Each delivered packet carries the index of its source, so the sink knows where it came from. The only state in the block is the set of alternating-priority pointers and the reset synchronizer.

Top module: `omega_net`

## Requirements
- R1: A delivered packet appears on output index equal to its 3-bit destination tag. `out_src` on that output holds the packet's input index and `out_data` holds its data unchanged.
- R2: A packet that is the only valid input in its cycle is always delivered, whatever its source and destination.
- R3: When two packets at one cell need the same output in the same cycle, exactly one of them leaves the cell. The other is not delivered and its `in_ready` is low in that cycle.
- R4: With fixed priority (`ARB` = 0), the packet on a cell's upper input always wins. A line is an upper input when its index after the shuffle is even. In the first column this means a source whose top index bit is 0 beats its partner, which is that source index plus 4.
- R5: With alternating priority (`ARB` = 1), every cell's pointer favours the upper input after reset. The pointer flips after each cycle in which a clash occurs at that cell, so repeated clashes alternate winners.
- R6: `in_ready[i]` is high only when `in_valid[i]` is high and that packet is delivered in the same cycle. An input with `in_valid` low produces nothing on any output.
- R7: With no valid inputs, every `out_valid` bit is 0 and every `in_ready` bit is 0. This holds in the first cycle after reset as well.
- R8: A packet blocked at a column does not occupy any link in later columns, so it cannot block another packet further on.
- R9: Before each column, line index b2 b1 b0 moves to position b1 b0 b2. Inside a cell, the upper output drives the even line and the lower output drives the odd line. With this wiring the identity mapping, where source i goes to destination i, passes with no blocking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 8 | Packet present on each source |
| in_dest | input | 24 | 3-bit destination tag per source, source i at bits [3i+2:3i] |
| in_data | input | 64 | Data per source, source i at bits [8i+7:8i] |
| in_ready | output | 8 | Packet of source i delivered this cycle |
| out_valid | output | 8 | Packet present on each sink |
| out_src | output | 24 | Source index of the packet on sink j, at bits [3j+2:3j] |
| out_data | output | 64 | Data of the packet on sink j, at bits [8j+7:8j] |

## Verification
The assertions assume that the source index in every lane comes from its input position and that inputs settle between clock edges. The bench drives inputs only just after a rising edge, so the clocked checks always see stable values. The alternating-pointer property assumes nothing else changes the pointer between two clashes. The bench therefore holds the same contending pair on consecutive cycles and runs that sequence straight after reset, before any other traffic. The sweeps draw destinations and valid masks from a shift-register sequence covering every source and sink. Expected results come from an arithmetic path model that follows each packet's line position column by column.

// File: rtl/omega_pkg.sv
package omega_pkg;
  typedef enum logic {ARB_FIXED = 1'b0, ARB_ROTATE = 1'b1} arb_mode_e;

  // Perfect shuffle: rotate a lg-bit line index left by one.
  function automatic int unsigned shuffle_pos(input int unsigned idx, input int unsigned lg);
    int unsigned msk;
    msk = (32'd1 << lg) - 32'd1;
    return ((idx << 1) | (idx >> (lg - 1))) & msk;
  endfunction
endpackage

// File: rtl/omega_switch2.sv
module omega_switch2 #(
  parameter int                   LW   = 15,
  parameter int                   SELB = 13,
  parameter omega_pkg::arb_mode_e ARB  = omega_pkg::ARB_FIXED
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] a_lane,
  input  logic [LW-1:0] b_lane,
  output logic [LW-1:0] u_lane,
  output logic [LW-1:0] l_lane
);
  logic a_vld, b_vld, a_sel, b_sel;
  logic clash, favor_b, a_go, b_go;

  assign a_vld = a_lane[LW-1];
  assign b_vld = b_lane[LW-1];
  assign a_sel = a_lane[SELB];
  assign b_sel = b_lane[SELB];
  assign clash = a_vld & b_vld & (a_sel == b_sel);
  assign a_go  = a_vld & ~(clash & favor_b);
  assign b_go  = b_vld & ~(clash & ~favor_b);

  generate
    if (ARB == omega_pkg::ARB_ROTATE) begin : g_rot
      logic prio_q, prio_d, prio_en;
      assign prio_en = clash;
      assign prio_d  = ~prio_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       prio_q <= 1'b0;
        else if (prio_en) prio_q <= prio_d;
      end
      assign favor_b = prio_q;

      // R5
      rr_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clash |=> (!clash || (a_go != $past(a_go))));
    end else begin : g_fix
      assign favor_b = 1'b0;

      // R4
      upper_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_vld |-> (a_sel ? (l_lane == a_lane) : (u_lane == a_lane)));
    end
  endgenerate

  always_comb begin
    u_lane = '0;
    l_lane = '0;
    if (a_go) begin
      if (a_sel) l_lane = a_lane;
      else       u_lane = a_lane;
    end
    if (b_go) begin
      if (b_sel) l_lane = b_lane;
      else       u_lane = b_lane;
    end
  end

  // R3
  clash_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clash |-> ($countones({u_lane[LW-1], l_lane[LW-1]}) == 1));
endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int                   N   = 8,
  parameter int                   LOG = 3,
  parameter int                   W   = 8,
  parameter int                   STG = 0,
  parameter omega_pkg::arb_mode_e ARB = omega_pkg::ARB_FIXED
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N*(1+2*LOG+W)-1:0]   in_flat,
  output logic [N*(1+2*LOG+W)-1:0]   out_flat
);
  localparam int LW   = 1 + 2*LOG + W;
  localparam int SELB = W + LOG + (LOG - 1 - STG);
  localparam int NSW  = N / 2;

  logic [LW-1:0] sh   [N];
  logic [LW-1:0] outl [N];

  generate
    for (genvar i = 0; i < N; i++) begin : g_shuf
      localparam int P = omega_pkg::shuffle_pos(i, LOG);
      assign sh[P] = in_flat[i*LW +: LW];
      assign out_flat[i*LW +: LW] = outl[i];
    end
    for (genvar k = 0; k < NSW; k++) begin : g_cell
      omega_switch2 #(.LW(LW), .SELB(SELB), .ARB(ARB)) u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_lane (sh[2*k]),
        .b_lane (sh[2*k+1]),
        .u_lane (outl[2*k]),
        .l_lane (outl[2*k+1])
      );
    end
  endgenerate
endmodule

// File: rtl/omega_net.sv
module omega_net #(
  parameter int                   N   = 8,
  parameter int                   W   = 8,
  parameter omega_pkg::arb_mode_e ARB = omega_pkg::ARB_FIXED
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     in_valid,
  input  logic [N*3-1:0]   in_dest,
  input  logic [N*W-1:0]   in_data,
  output logic [N-1:0]     in_ready,
  output logic [N*3-1:0]   out_src,
  output logic [N-1:0]     out_valid,
  output logic [N*W-1:0]   out_data
);
  localparam int LOG = $clog2(N);
  localparam int LW  = 1 + 2*LOG + W;

  logic [1:0] rst_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_int = rst_q[1];

  logic [N*LW-1:0] col [LOG+1];

  generate
    for (genvar i = 0; i < N; i++) begin : g_in
      assign col[0][i*LW +: LW] = {in_valid[i], in_dest[i*LOG +: LOG], LOG'(i), in_data[i*W +: W]};
    end
    for (genvar s = 0; s < LOG; s++) begin : g_stg
      omega_stage #(.N(N), .LOG(LOG), .W(W), .STG(s), .ARB(ARB)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n_int),
        .in_flat  (col[s]),
        .out_flat (col[s+1])
      );
    end
    for (genvar j = 0; j < N; j++) begin : g_out
      logic [LW-1:0] ln;
      assign ln = col[LOG][j*LW +: LW];
      assign out_valid[j]           = ln[LW-1];
      assign out_src[j*LOG +: LOG]  = ln[W+LOG-1 -: LOG];
      assign out_data[j*W +: W]     = ln[W-1:0];

      // R1
      dest_match_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
        ln[LW-1] |-> (ln[LW-2 -: LOG] == LOG'(j)));
    end
  endgenerate

  always_comb begin
    in_ready = '0;
    for (int j = 0; j < N; j++) begin
      if (out_valid[j]) in_ready[out_src[j*LOG +: LOG]] = 1'b1;
    end
  end

  // R6
  ready_valid_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (in_ready & ~in_valid) == '0);

  // R2
  lone_pass_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    ($countones(in_valid) == 1) |-> (in_ready == in_valid));
endmodule

// File: tb/tb_omega_net.sv
module tb_omega_net;
  localparam int N = 8;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   in_valid = '0;
  logic [N*3-1:0] in_dest = '0;
  logic [N*W-1:0] in_data = '0;
  logic [N-1:0]   in_ready, rr_ready, out_valid, rr_valid;
  logic [N*3-1:0] out_src, rr_src;
  logic [N*W-1:0] out_data, rr_data;

  always #10 clk = ~clk;

  omega_net #(.N(N), .W(W), .ARB(omega_pkg::ARB_FIXED)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data),
    .in_ready(in_ready), .out_src(out_src), .out_valid(out_valid), .out_data(out_data));

  omega_net #(.N(N), .W(W), .ARB(omega_pkg::ARB_ROTATE)) dut_rr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data),
    .in_ready(rr_ready), .out_src(rr_src), .out_valid(rr_valid), .out_data(rr_data));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int bv [N];
  int bd [N];
  int bdat [N];
  int alive [N];
  int lfsr = 16'hACE1;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rotl3(input int p);
    return ((p << 1) | (p >> 2)) & 7;
  endfunction

  // Path model: follow each packet's line position column by column.
  task automatic model();
    int pos [N];
    for (int s = 0; s < N; s++) begin
      alive[s] = bv[s];
      pos[s] = s;
    end
    for (int st = 0; st < 3; st++) begin
      for (int s = 0; s < N; s++) pos[s] = rotl3(pos[s]);
      for (int s = 0; s < N; s++)
        for (int t = s + 1; t < N; t++)
          if (alive[s] != 0 && alive[t] != 0 && (pos[s] >> 1) == (pos[t] >> 1) &&
              ((bd[s] >> (2 - st)) & 1) == ((bd[t] >> (2 - st)) & 1)) begin
            if (pos[s] & 1) alive[s] = 0;
            else            alive[t] = 0;
          end
      for (int s = 0; s < N; s++)
        pos[s] = (pos[s] & 6) | ((bd[s] >> (2 - st)) & 1);
    end
  endtask

  task automatic drive();
    @(posedge clk);
    #2;
    for (int s = 0; s < N; s++) begin
      in_valid[s] = bv[s][0];
      in_dest[s*3 +: 3] = bd[s][2:0];
      in_data[s*W +: W] = bdat[s][W-1:0];
    end
    @(negedge clk);
  endtask

  task automatic check_fixed(input string req);
    model();
    for (int j = 0; j < N; j++) begin
      int es = -1;
      for (int s = 0; s < N; s++) if (alive[s] != 0 && bd[s] == j) es = s;
      check(req, $sformatf("out_valid[%0d]", j), int'(out_valid[j]), (es >= 0) ? 1 : 0);
      if (es >= 0) begin
        check("R1", $sformatf("out_src[%0d]", j), int'(out_src[j*3 +: 3]), es);
        check("R1", $sformatf("out_data[%0d]", j), int'(out_data[j*W +: W]), bdat[es]);
      end
    end
    for (int s = 0; s < N; s++)
      check(req, $sformatf("in_ready[%0d]", s), int'(in_ready[s]), alive[s]);
  endtask

  task automatic clear();
    for (int s = 0; s < N; s++) begin
      bv[s] = 0; bd[s] = 0; bdat[s] = 0;
    end
  endtask

  function automatic int step(input int v);
    return ((v >> 1) ^ ((v & 1) ? 16'hB400 : 0)) & 16'hFFFF;
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    clear();
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R7: idle after reset
    check("R7", "out_valid idle", int'(out_valid), 0);
    check("R7", "in_ready idle", int'(in_ready), 0);
    check("R7", "rr out_valid idle", int'(rr_valid), 0);

    // R5 / R4: sources 0 and 4 clash at the first column (dest 0 and 2, top bit 0)
    clear();
    bv[0] = 1; bd[0] = 0; bdat[0] = 8'h11;
    bv[4] = 1; bd[4] = 2; bdat[4] = 8'h44;
    for (int c = 0; c < 4; c++) begin
      drive();
      check("R5", "rr ready src0", int'(rr_ready[0]), (c % 2 == 0) ? 1 : 0);
      check("R5", "rr ready src4", int'(rr_ready[4]), (c % 2 == 1) ? 1 : 0);
      check("R4", "fixed ready src0", int'(in_ready[0]), 1);
      check("R3", "fixed ready src4", int'(in_ready[4]), 0);
    end

    // R2: every lone source/destination pair
    for (int s = 0; s < N; s++)
      for (int d = 0; d < N; d++) begin
        clear();
        bv[s] = 1; bd[s] = d; bdat[s] = (s * 8 + d) & 255;
        drive();
        check_fixed("R2");
      end

    // R9: identity mapping passes without blocking
    clear();
    for (int s = 0; s < N; s++) begin
      bv[s] = 1; bd[s] = s; bdat[s] = 8'hA0 + s;
    end
    drive();
    check("R9", "identity all ready", int'(in_ready), 255);
    check_fixed("R9");

    // R8: directed loser that would otherwise collide further on
    clear();
    bv[0] = 1; bd[0] = 0; bdat[0] = 8'h01;
    bv[4] = 1; bd[4] = 1; bdat[4] = 8'h02;
    bv[2] = 1; bd[2] = 3; bdat[2] = 8'h03;
    bv[6] = 1; bd[6] = 5; bdat[6] = 8'h04;
    drive();
    check_fixed("R8");

    // R3 / R6 / R8: swept patterns, random destinations and valid masks
    for (int p = 0; p < 400; p++) begin
      clear();
      for (int s = 0; s < N; s++) begin
        lfsr = step(lfsr);
        bd[s] = lfsr & 7;
        bv[s] = (p < 200) ? 1 : ((lfsr >> 5) & 1);
        bdat[s] = (lfsr >> 3) & 255;
      end
      drive();
      check_fixed((p < 200) ? "R3" : "R6");
    end

    // R7: idle again
    clear();
    drive();
    check("R7", "out_valid idle end", int'(out_valid), 0);
    check("R6", "in_ready idle end", int'(in_ready), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule